// File: doc/BRIEF.md
# Pixel Pedestal and Common-Mode Zero Suppressor

This block reduces the volume of raw pixel readout data. Every incoming ADC sample carries its row and column address; the block looks up a stored baseline (pedestal) for that pixel and subtracts it. Samples are gathered into segments of a fixed power-of-two length. Once a segment is full, the block takes the mean of its baseline-corrected values as the offset that the whole segment shares. It removes that offset from each sample and passes on only those samples whose final amplitude is strictly above a programmable threshold. Each passed sample is tagged with its address.

The baseline table has its own write port. A write is taken only while the block holds no part of a segment. A calibration bypass forwards every baseline-corrected sample, with no offset removal and no threshold. All amplitudes are signed and clip at the output width.

Top module: `pixel_zsup`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0.
- R2: For a sample at (row, col), the baseline-corrected value is raw minus the stored pedestal at table address {row, col}. The whole table reads zero after reset.
- R3: The segment offset is floor(sum of the segment's corrected values / SEG_LEN), which rounds toward minus infinity. SEG_LEN is 2**SEG_LOG2 consecutive accepted samples, 4 by default. In normal mode the offset is subtracted from each corrected value of the same segment.
- R4: In normal mode a sample yields a hit only when its final signed amplitude is strictly greater than the signed `thr`. A sample equal to `thr` yields no hit.
- R5: Amplitudes saturate at the signed OUT_W range, -512..511 by default, and do not wrap.
- R6: Each hit carries the row and column of its sample. Hits leave in the order the samples arrived.
- R7: After the last sample of a segment is accepted, `s_ready` stays low until every sample of that segment has been evaluated and every hit from it has been taken.
- R8: With `bypass` set, every sample of a segment is emitted with amplitude = saturated (raw - pedestal). No offset is subtracted and no threshold is applied.
- R9: `s_ready` is low in any cycle with `ped_we` high. A table write is stored only when no segment is partly filled or draining; a write at any other time is dropped and later samples still see the old pedestal.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_row`, `m_col` and `m_amp` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_row | input | ROW_W | Row address of the sample |
| s_col | input | COL_W | Column address of the sample |
| s_raw | input | ADC_W | Unsigned raw ADC code |
| ped_we | input | 1 | Pedestal table write strobe |
| ped_row | input | ROW_W | Row of the pedestal entry |
| ped_col | input | COL_W | Column of the pedestal entry |
| ped_val | input | ADC_W | Unsigned pedestal value |
| thr | input | OUT_W | Signed hit threshold |
| bypass | input | 1 | Calibration mode: emit every corrected sample |
| m_valid | output | 1 | Hit valid |
| m_ready | input | 1 | Hit accepted when high together with m_valid |
| m_row | output | ROW_W | Row of the hit |
| m_col | output | COL_W | Column of the hit |
| m_amp | output | OUT_W | Signed corrected amplitude |

## Verification
The hold and threshold properties assume that `thr` and `bypass` change only while the block is idle. If either changed while a segment drains, a held hit could legally vanish and the comparison would use a different bound. The stimulus therefore waits until all expected hits are taken and the drain is over before it touches either input. Deliberate table writes are made at idle. The dropped-write case is driven mid-segment on purpose, and its effect is observed through the amplitudes of later segments.

// File: rtl/pixel_zsup_pkg.sv
package pixel_zsup_pkg;
   typedef enum logic {
      ST_FILL  = 1'b0,
      ST_DRAIN = 1'b1
   } seg_state_e;
endpackage

// File: rtl/pixel_zsup_pedram.sv
module pixel_zsup_pedram #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pixel_zsup_segbuf.sv
module pixel_zsup_segbuf
   import pixel_zsup_pkg::*;
#(
   parameter int SEG_LOG2 = 2,
   parameter int VAL_W    = 13,
   parameter int TAG_W    = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic signed [VAL_W-1:0] push_val,
   input  logic [TAG_W-1:0]        push_tag,
   input  logic                    advance,
   output logic                    fill_o,
   output logic                    drain_o,
   output logic                    idle_o,
   output logic signed [VAL_W-1:0] out_val,
   output logic [TAG_W-1:0]        out_tag,
   output logic signed [VAL_W-1:0] cm_o
);
   localparam int SEG_LEN = 1 << SEG_LOG2;
   localparam int SUM_W   = VAL_W + SEG_LOG2;
   localparam logic [SEG_LOG2-1:0] LAST = SEG_LOG2'(SEG_LEN - 1);

   seg_state_e              state_q;
   logic [SEG_LOG2-1:0]     idx_q;
   logic signed [SUM_W-1:0] sum_q;
   logic signed [VAL_W-1:0] cm_q;
   logic signed [VAL_W-1:0] val_q [SEG_LEN];
   logic [TAG_W-1:0]        tag_q [SEG_LEN];

   logic signed [SUM_W-1:0] push_ext;
   logic signed [SUM_W-1:0] sum_nxt;
   logic signed [SUM_W-1:0] mean_nxt;

   assign push_ext = {{SEG_LOG2{push_val[VAL_W-1]}}, push_val};
   assign sum_nxt  = sum_q + push_ext;
   assign mean_nxt = sum_nxt >>> SEG_LOG2;

   always_ff @(posedge clk) begin
      if (push) begin
         val_q[idx_q] <= push_val;
         tag_q[idx_q] <= push_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FILL;
         idx_q   <= '0;
         sum_q   <= '0;
         cm_q    <= '0;
      end else begin
         case (state_q)
            ST_FILL: begin
               if (push) begin
                  if (idx_q == LAST) begin
                     state_q <= ST_DRAIN;
                     idx_q   <= '0;
                     sum_q   <= '0;
                     cm_q    <= mean_nxt[VAL_W-1:0];
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     sum_q <= sum_nxt;
                  end
               end
            end
            ST_DRAIN: begin
               if (advance) begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == LAST) state_q <= ST_FILL;
               end
            end
            default: state_q <= ST_FILL;
         endcase
      end
   end

   assign fill_o  = (state_q == ST_FILL);
   assign drain_o = (state_q == ST_DRAIN);
   assign idle_o  = fill_o && (idx_q == '0);
   assign out_val = val_q[idx_q];
   assign out_tag = tag_q[idx_q];
   assign cm_o    = cm_q;
endmodule

// File: rtl/pixel_zsup_emit.sv
module pixel_zsup_emit #(
   parameter int VAL_W = 13,
   parameter int OUT_W = 10
) (
   input  logic                    active,
   input  logic                    bypass,
   input  logic signed [VAL_W-1:0] val,
   input  logic signed [VAL_W-1:0] cm,
   input  logic signed [OUT_W-1:0] thr,
   output logic signed [OUT_W-1:0] amp,
   output logic                    pass
);
   localparam int FW = VAL_W + 1;

   logic signed [FW-1:0] val_x;
   logic signed [FW-1:0] cm_x;
   logic signed [FW-1:0] corr;

   assign val_x = {val[VAL_W-1], val};
   assign cm_x  = {cm[VAL_W-1], cm};
   assign corr  = bypass ? val_x : (val_x - cm_x);

   generate
      if (OUT_W >= FW) begin : g_wide
         assign amp = OUT_W'(corr);
      end else begin : g_clip
         localparam logic signed [FW-1:0] HI = FW'((1 << (OUT_W - 1)) - 1);
         localparam logic signed [FW-1:0] LO = ~HI;
         always_comb begin
            if (corr > HI)      amp = HI[OUT_W-1:0];
            else if (corr < LO) amp = LO[OUT_W-1:0];
            else                amp = corr[OUT_W-1:0];
         end
      end
   endgenerate

   assign pass = active && (bypass || (amp > thr));
endmodule

// File: rtl/pixel_zsup.sv
module pixel_zsup #(
   parameter int ADC_W    = 12,
   parameter int ROW_W    = 4,
   parameter int COL_W    = 5,
   parameter int SEG_LOG2 = 2,
   parameter int OUT_W    = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic [ROW_W-1:0]        s_row,
   input  logic [COL_W-1:0]        s_col,
   input  logic [ADC_W-1:0]        s_raw,
   input  logic                    ped_we,
   input  logic [ROW_W-1:0]        ped_row,
   input  logic [COL_W-1:0]        ped_col,
   input  logic [ADC_W-1:0]        ped_val,
   input  logic signed [OUT_W-1:0] thr,
   input  logic                    bypass,
   output logic                    m_valid,
   input  logic                    m_ready,
   output logic [ROW_W-1:0]        m_row,
   output logic [COL_W-1:0]        m_col,
   output logic signed [OUT_W-1:0] m_amp
);
   localparam int VAL_W = ADC_W + 1;
   localparam int TAG_W = ROW_W + COL_W;

   if (SEG_LOG2 < 1) begin : g_bad_seg
      $error("SEG_LOG2 must be at least 1");
   end
   if (ADC_W < 2) begin : g_bad_adc
      $error("ADC_W must be at least 2");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("OUT_W must be at least 2");
   end
   if ((1 << SEG_LOG2) > (1 << COL_W)) begin : g_bad_cols
      $error("segment longer than a row");
   end

   logic                    fill, drain, idle, accept, advance;
   logic [ADC_W-1:0]        ped_rd;
   logic signed [VAL_W-1:0] diff;
   logic signed [VAL_W-1:0] seg_val, seg_cm;
   logic [TAG_W-1:0]        seg_tag;
   logic                    hit;

   assign s_ready = fill && !ped_we;
   assign accept  = s_valid && s_ready;

   pixel_zsup_pedram #(
      .ADDR_W (TAG_W),
      .DATA_W (ADC_W)
   ) u_pedram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ped_we && idle),
      .wr_addr ({ped_row, ped_col}),
      .wr_data (ped_val),
      .rd_addr ({s_row, s_col}),
      .rd_data (ped_rd)
   );

   assign diff = $signed({1'b0, s_raw}) - $signed({1'b0, ped_rd});

   pixel_zsup_segbuf #(
      .SEG_LOG2 (SEG_LOG2),
      .VAL_W    (VAL_W),
      .TAG_W    (TAG_W)
   ) u_segbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .push_val (diff),
      .push_tag ({s_row, s_col}),
      .advance  (advance),
      .fill_o   (fill),
      .drain_o  (drain),
      .idle_o   (idle),
      .out_val  (seg_val),
      .out_tag  (seg_tag),
      .cm_o     (seg_cm)
   );

   pixel_zsup_emit #(
      .VAL_W (VAL_W),
      .OUT_W (OUT_W)
   ) u_emit (
      .active (drain),
      .bypass (bypass),
      .val    (seg_val),
      .cm     (seg_cm),
      .thr    (thr),
      .amp    (m_amp),
      .pass   (hit)
   );

   assign m_valid = hit;
   assign advance = drain && (!hit || m_ready);
   assign m_row   = seg_tag[TAG_W-1:COL_W];
   assign m_col   = seg_tag[COL_W-1:0];
endmodule

// File: rtl/pixel_zsup_chk.sv
module pixel_zsup_chk #(
   parameter int ROW_W = 4,
   parameter int COL_W = 5,
   parameter int OUT_W = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    s_ready,
   input logic                    ped_we,
   input logic                    bypass,
   input logic signed [OUT_W-1:0] thr,
   input logic                    m_valid,
   input logic                    m_ready,
   input logic [ROW_W-1:0]        m_row,
   input logic [COL_W-1:0]        m_col,
   input logic signed [OUT_W-1:0] m_amp
);
   AST_HIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_row) && $stable(m_col) && $stable(m_amp))); // R10

   AST_NO_INTAKE_WHILE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> !s_ready); // R7

   AST_WRITE_BLOCKS_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ped_we |-> !s_ready); // R9

   AST_HIT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !bypass) |-> (m_amp > thr)); // R4
endmodule

bind pixel_zsup pixel_zsup_chk #(
   .ROW_W (ROW_W),
   .COL_W (COL_W),
   .OUT_W (OUT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_ready (s_ready),
   .ped_we  (ped_we),
   .bypass  (bypass),
   .thr     (thr),
   .m_valid (m_valid),
   .m_ready (m_ready),
   .m_row   (m_row),
   .m_col   (m_col),
   .m_amp   (m_amp)
);

// File: tb/pixel_zsup_bench.sv
`timescale 1ns/1ps
module pixel_zsup_bench;
   localparam int ROW_W = 4, COL_W = 5, ADC_W = 12, SEG_LOG2 = 2, OUT_W = 10;
   localparam int SEG = 4;
   localparam int NCOL = 32;

   logic clk = 0, rst_n = 0;
   logic s_valid = 0, s_ready;
   logic [ROW_W-1:0] s_row = '0;
   logic [COL_W-1:0] s_col = '0;
   logic [ADC_W-1:0] s_raw = '0;
   logic ped_we = 0;
   logic [ROW_W-1:0] ped_row = '0;
   logic [COL_W-1:0] ped_col = '0;
   logic [ADC_W-1:0] ped_val = '0;
   logic signed [OUT_W-1:0] thr = '0;
   logic bypass = 0;
   logic m_valid, m_ready = 0;
   logic [ROW_W-1:0] m_row;
   logic [COL_W-1:0] m_col;
   logic signed [OUT_W-1:0] m_amp;

   typedef struct packed {
      logic [ROW_W-1:0]        r;
      logic [COL_W-1:0]        c;
      logic signed [OUT_W-1:0] a;
   } hit_t;

   hit_t exp_q[$];
   int   ped_m[512];
   int   n_chk = 0, n_fail = 0, cyc = 0, rmode = 0, thr_i = 0;
   bit   byp_i = 0, done = 0, stall_prev = 0;
   hit_t prev_h;

   always #2 clk = ~clk;

   pixel_zsup #(.ADC_W(ADC_W), .ROW_W(ROW_W), .COL_W(COL_W),
                .SEG_LOG2(SEG_LOG2), .OUT_W(OUT_W)) u_pixel_zsup (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_row(s_row), .s_col(s_col), .s_raw(s_raw), .ped_we(ped_we),
      .ped_row(ped_row), .ped_col(ped_col), .ped_val(ped_val), .thr(thr),
      .bypass(bypass), .m_valid(m_valid), .m_ready(m_ready), .m_row(m_row),
      .m_col(m_col), .m_amp(m_amp));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      #1;
      case (rmode)
         0: m_ready = 1'b1;
         1: m_ready = 1'b0;
         default: m_ready = 1'($urandom % 2);
      endcase
   end

   // Output monitor: compares every clock against the model queue.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (stall_prev)
            chk(m_valid && m_row == prev_h.r && m_col == prev_h.c && m_amp == prev_h.a,
                "R10", "stalled hit word changed", int'(m_amp), int'(prev_h.a));
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R4", "hit with none expected", int'(m_amp), 0);
            end else begin
               hit_t e;
               e = exp_q.pop_front();
               chk(m_row == e.r && m_col == e.c, "R6", "hit address",
                   int'({m_row, m_col}), int'({e.r, e.c}));
               chk(m_amp == e.a, "R2,R3,R5,R8", "hit amplitude", int'(m_amp), int'(e.a));
            end
         end
         stall_prev = m_valid && !m_ready;
         prev_h = '{r: m_row, c: m_col, a: m_amp};
         if (cyc > 150000) begin
            chk(0, "R1", "watchdog expired", cyc, 150000);
            finish_run();
         end
      end
   end

   task automatic set_mode(input int t, input bit b);
      thr_i = t; byp_i = b;
      @(posedge clk); #1;
      thr = OUT_W'(t); bypass = b;
   endtask

   task automatic write_ped(input int r, input int c, input int v, input bit taken);
      @(posedge clk); #1;
      ped_we = 1; ped_row = ROW_W'(r); ped_col = COL_W'(c); ped_val = ADC_W'(v);
      @(posedge clk); #1;
      ped_we = 0;
      if (taken) ped_m[r*NCOL + c] = v;
   endtask

   task automatic send_sample(input int r, input int c, input int raw);
      @(posedge clk); #1;
      s_valid = 1; s_row = ROW_W'(r); s_col = COL_W'(c); s_raw = ADC_W'(raw);
      forever begin
         @(negedge clk);
         if (s_ready) break;
      end
      @(posedge clk); #1;
      s_valid = 0;
   endtask

   // Behavioural model of one segment: baseline, floor mean, clip, threshold.
   task automatic model_seg(input int r, input int c0, input int raw[SEG]);
      int d[SEG];
      int sum, cm, v;
      sum = 0;
      for (int i = 0; i < SEG; i++) begin
         d[i] = raw[i] - ped_m[r*NCOL + c0 + i];
         sum += d[i];
      end
      cm = sum >>> SEG_LOG2;
      for (int i = 0; i < SEG; i++) begin
         v = byp_i ? d[i] : d[i] - cm;
         if (v > 511) v = 511;
         if (v < -512) v = -512;
         if (byp_i || v > thr_i)
            exp_q.push_back('{r: ROW_W'(r), c: COL_W'(c0 + i), a: OUT_W'(v)});
      end
   endtask

   task automatic run_seg(input int r, input int c0, input int raw[SEG],
                          input int wr_at, input int wr_v);
      model_seg(r, c0, raw);
      for (int i = 0; i < SEG; i++) begin
         if (i == wr_at) write_ped(r, c0 + SEG - 1, wr_v, 0);
         send_sample(r, c0 + i, raw[i]);
      end
   endtask

   task automatic wait_drain();
      int k;
      k = 0;
      while (exp_q.size() != 0 && k < 5000) begin
         @(negedge clk);
         k++;
      end
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "hits still pending", exp_q.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) ped_m[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(s_ready == 1'b1, "R1", "s_ready after reset", int'(s_ready), 1);
      chk(m_valid == 1'b0, "R1", "m_valid after reset", int'(m_valid), 0);

      // R2: pedestals for row 1
      for (int c = 0; c < SEG; c++) write_ped(1, c, 100 + 10*c, 1);
      rmode = 0;
      set_mode(20, 0);
      run_seg(1, 0, '{105, 200, 118, 300}, -1, 0);   // R3 R4: hits 25 and 105
      wait_drain();
      set_mode(25, 0);
      run_seg(1, 0, '{105, 200, 118, 300}, -1, 0);   // R4: equal to thr dropped
      wait_drain();
      set_mode(20, 0);
      run_seg(1, 0, '{150, 160, 170, 180}, -1, 0);   // R3: flat offset removed
      wait_drain();
      set_mode(0, 0);
      run_seg(2, 0, '{4095, 0, 0, 0}, -1, 0);        // R5: clip at 511
      wait_drain();
      write_ped(2, 4, 1, 1);
      run_seg(2, 4, '{0, 0, 0, 0}, -1, 0);           // R3: floor of -1/4 is -1
      wait_drain();
      set_mode(0, 1);
      run_seg(1, 0, '{0, 4095, 110, 130}, -1, 0);    // R8: all emitted, -100 and 511
      wait_drain();

      // R7 R10: backpressure
      set_mode(20, 0);
      rmode = 1;
      run_seg(1, 0, '{105, 200, 118, 300}, -1, 0);
      repeat (5) @(negedge clk);
      chk(s_ready == 1'b0, "R7", "s_ready while hit stalled", int'(s_ready), 0);
      chk(m_valid == 1'b1, "R10", "m_valid while stalled", int'(m_valid), 1);
      rmode = 0;
      wait_drain();
      chk(s_ready == 1'b1, "R7", "s_ready after drain", int'(s_ready), 1);

      // R9: write mid-segment dropped, later write at idle taken
      set_mode(0, 0);
      run_seg(3, 0, '{50, 60, 70, 80}, 2, 500);
      wait_drain();
      run_seg(3, 0, '{50, 60, 70, 80}, -1, 0);
      wait_drain();
      write_ped(3, 3, 40, 1);
      run_seg(3, 0, '{50, 60, 70, 200}, -1, 0);
      wait_drain();

      // mixed traffic
      rmode = 2;
      for (int n = 0; n < 300; n++) begin
         int r, c0;
         int raw[SEG];
         r = $urandom_range(0, 15);
         c0 = SEG * $urandom_range(0, NCOL/SEG - 1);
         if (n % 7 == 0) write_ped(r, c0 + $urandom_range(0, SEG-1), $urandom_range(900, 1200), 1);
         set_mode($urandom_range(0, 120) - 20, ($urandom % 8) == 0);
         for (int i = 0; i < SEG; i++) raw[i] = $urandom_range(950, 1300);
         run_seg(r, c0, raw, -1, 0);
         wait_drain();
      end
      rmode = 0;
      finish_run();
   end
endmodule